// File: doc/BRIEF.md
# CF Common-Space Address Decoder and Byte-Lane Assembler

This block sits between a PC Card common-memory/I/O access bus and an ATA task-file register port. The card's configured addressing mode selects how an incoming address is matched. There are four modes: a 2 KiB-aligned memory window, a contiguous 16-byte I/O block, the primary legacy I/O pair, and the secondary legacy I/O pair. Each hit is folded into a 4-bit register index. A miss is invisible: reads float high and writes are dropped.

The block turns byte-wide data traffic into 16-bit data-port transfers. It uses a byte latch and a cycle toggle to do this. It also serves three registers locally:
- alternate status, passed through from the task file's status output;
- a synthesised device-address byte, built from the inverted drive-select nibble;
- a device-control register, whose writes request an interrupt re-evaluation and can request a soft reset.

Any other task-file write first wakes the card when it is powered down, and then goes on to the task file.

Top module: `cf_common_decoder`

## Requirements
- R1: In mode 0 (memory-mapped), an access hits when the address ANDed with ~0x3FF equals 0x400. The index is then address bits [3:0]. Any other address misses.
- R2: In mode 1 (contiguous I/O), every address hits and the index is address bits [3:0].
- R3: In mode 2 (primary I/O), addresses 0x1F0–0x1FF hit with index = address bits [3:0]. Addresses 0x3F0–0x3FF hit with index = (address − 0x3E8) mod 16, so 0x3F6 maps to 0xE and 0x3F7 maps to 0xF. Everything else misses.
- R4: In mode 3 (secondary I/O), 0x170–0x17F and 0x370–0x37F hit, remapped the same way (upper window minus 0x368). Everything else misses.
- R5: A miss reads as 0xFFFF. It issues no task-file access, raises no strobe, and changes no local state.
- R6: Index 0x0 is a 16-bit pass-through to task-file index 0 in both directions.
- R7: At index 0x8, with the toggle clear, a write stores wdata[7:0] in the latch. With the toggle set, a write issues a task-file write to index 0 of {wdata[7:0], latch[7:0]}. Each index-0x8 access flips the toggle.
- R8: A write at index 0x9 stores wdata[7:0] in the latch and flips the toggle, with no task-file access. A following index-0x8 write therefore issues the paired word.
- R9: At index 0x8, with the toggle clear, a read fetches the index-0 word into the latch and returns its low byte. With the toggle set, a read returns latch[15:8] with no task-file access. An index-0x9 read returns latch[15:8] and does not flip the toggle. All byte reads zero the upper lane.
- R10: Index 0xD maps to task-file index 1 for reads and writes.
- R11: An index-0xE read returns alt_stat_i. An index-0xE write loads ctrl_o on the next edge and pulses irq_eval_o. It pulses soft_rst_o when wdata bit 2 is set.
- R12: An index-0xF read returns 0xC2 OR (~sel_nib_i << 2).
- R13: A write to any index other than 0x0, 0x8, 0x9, 0xD or 0xE is forwarded to the task file. In the same cycle, it pulses wake_o if pwrdn_i is high.
- R14: Reset clears the toggle, the byte latch and ctrl_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Addressing mode from the configuration register |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data (combinational) |
| tf_req_o | output | 1 | Task-file access strobe |
| tf_we_o | output | 1 | Task-file write enable |
| tf_idx_o | output | 4 | Task-file register index |
| tf_wdata_o | output | DATA_W | Task-file write data |
| tf_rdata_i | input | DATA_W | Task-file read data |
| alt_stat_i | input | 8 | Device status for the alternate-status read |
| sel_nib_i | input | 4 | Low nibble of the device-select register |
| pwrdn_i | input | 1 | Card is in power-down |
| wake_o | output | 1 | Request: set card ready and leave power-down |
| ctrl_o | output | 8 | Device-control register |
| soft_rst_o | output | 1 | Soft-reset request pulse |
| irq_eval_o | output | 1 | Interrupt re-evaluation pulse |

## Verification
The bench pairs bytes in both orders: two index-0x8 writes, and an index-0x9 write followed by an index-0x8 write. A design with a swapped lane, or one that fails to toggle on index 0x9, would put a byte-swapped or missing word on the stub's data port. It also checks that the second half of a byte read does not fetch again. A refetch would advance the device's data pointer and lose a word.

For the legacy modes, upper-window addresses are checked to land on indices 0xE/0xF. Addresses in the other mode's window are checked to miss. A wrong remap offset would send alternate-status reads to the task file. The bench also confirms that a missed write leaves both the device-control register and the byte toggle untouched, and that wake-up only happens for forwarded writes made while powered down.

// File: rtl/cf_dec_pkg.sv
package cf_dec_pkg;
  typedef enum logic [1:0] {
    MODE_MEM  = 2'd0,
    MODE_IO16 = 2'd1,
    MODE_PRI  = 2'd2,
    MODE_SEC  = 2'd3
  } cf_mode_e;

  localparam logic [3:0] IDX_DATA    = 4'h0;
  localparam logic [3:0] IDX_TF_ERR  = 4'h1;
  localparam logic [3:0] IDX_BYTE    = 4'h8;
  localparam logic [3:0] IDX_ODD     = 4'h9;
  localparam logic [3:0] IDX_ERRFEAT = 4'hD;
  localparam logic [3:0] IDX_ALTCTL  = 4'hE;
  localparam logic [3:0] IDX_DEVADR  = 4'hF;

  localparam int unsigned CTRL_SRST_BIT = 2;
  localparam logic [7:0]  DEVADR_BASE   = 8'hC2;
endpackage

// File: rtl/cf_window_dec.sv
module cf_window_dec
  import cf_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [3:0]        idx_o
);
  localparam logic [ADDR_W-1:0] MEM_MASK  = ~ADDR_W'(32'h3FF);
  localparam logic [ADDR_W-1:0] MEM_BASE  = ADDR_W'(32'h400);
  localparam logic [ADDR_W-1:0] WIN_MASK  = ~ADDR_W'(32'hF);
  localparam logic [ADDR_W-1:0] PRI_LO    = ADDR_W'(32'h1F0);
  localparam logic [ADDR_W-1:0] PRI_HI    = ADDR_W'(32'h3F0);
  localparam logic [ADDR_W-1:0] SEC_LO    = ADDR_W'(32'h170);
  localparam logic [ADDR_W-1:0] SEC_HI    = ADDR_W'(32'h370);
  // upper window minus 0x3E8 / 0x368 == low nibble plus 8 (mod 16)
  localparam logic [3:0]        HI_OFFSET = 4'h8;

  cf_mode_e          mode;
  logic [ADDR_W-1:0] win;
  logic [3:0]        hi_idx;

  assign mode   = cf_mode_e'(mode_i);
  assign win    = addr_i & WIN_MASK;
  assign hi_idx = addr_i[3:0] + HI_OFFSET;

  always_comb begin
    hit_o = 1'b0;
    idx_o = addr_i[3:0];
    case (mode)
      MODE_MEM:  hit_o = ((addr_i & MEM_MASK) == MEM_BASE);
      MODE_IO16: hit_o = 1'b1;
      MODE_PRI: begin
        if (win == PRI_HI) begin
          hit_o = 1'b1;
          idx_o = hi_idx;
        end else begin
          hit_o = (win == PRI_LO);
        end
      end
      MODE_SEC: begin
        if (win == SEC_HI) begin
          hit_o = 1'b1;
          idx_o = hi_idx;
        end else begin
          hit_o = (win == SEC_LO);
        end
      end
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cf_byte_pair.sv
module cf_byte_pair #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_step_i,
  input  logic              wr_odd_i,
  input  logic              rd_step_i,
  input  logic [DATA_W/2-1:0] wbyte_i,
  input  logic [DATA_W-1:0] fetch_i,
  output logic              cycle_o,
  output logic [DATA_W-1:0] latch_o
);
  localparam int unsigned BYTE_W = DATA_W / 2;

  logic cycle_q;
  logic [DATA_W-1:0] latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cycle_q <= 1'b0;
      latch_q <= '0;
    end else begin
      if (wr_odd_i || (wr_step_i && !cycle_q))
        latch_q <= {{BYTE_W{1'b0}}, wbyte_i};
      else if (rd_step_i && !cycle_q)
        latch_q <= fetch_i;
      if (wr_step_i || wr_odd_i || rd_step_i)
        cycle_q <= ~cycle_q;
    end
  end

  assign cycle_o = cycle_q;
  assign latch_o = latch_q;

  // R7 / R8 / R9: every paired-byte step flips the toggle
  a_r7_toggle_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_step_i || wr_odd_i || rd_step_i) |=> (cycle_o != $past(cycle_o)));
  // R9: second half of a read keeps the fetched word
  a_r9_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_step_i && cycle_o && !wr_step_i && !wr_odd_i) |=> $stable(latch_o));
endmodule

// File: rtl/cf_ctrl_reg.sv
module cf_ctrl_reg
  import cf_dec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ctrl_o,
  output logic       srst_o,
  output logic       eval_o
);
  logic [7:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wdata_i;
  end

  assign ctrl_o = ctrl_q;
  assign srst_o = wr_i & wdata_i[CTRL_SRST_BIT];
  assign eval_o = wr_i;

  // R11: a device-control write is visible on the next cycle
  a_r11_ctrl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (ctrl_o == $past(wdata_i)));
  // R11: without a write the register holds
  a_r11_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_o));
endmodule

// File: rtl/cf_common_decoder.sv
module cf_common_decoder
  import cf_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tf_req_o,
  output logic              tf_we_o,
  output logic [3:0]        tf_idx_o,
  output logic [DATA_W-1:0] tf_wdata_o,
  input  logic [DATA_W-1:0] tf_rdata_i,
  input  logic [7:0]        alt_stat_i,
  input  logic [3:0]        sel_nib_i,
  input  logic              pwrdn_i,
  output logic              wake_o,
  output logic [7:0]        ctrl_o,
  output logic              soft_rst_o,
  output logic              irq_eval_o
);
  localparam int unsigned BYTE_W = DATA_W / 2;
  localparam logic [BYTE_W-1:0] ZB = '0;

  logic              hit;
  logic [3:0]        idx;
  logic              cycle;
  logic [DATA_W-1:0] latch;
  logic              wr_step, wr_odd, rd_step, ctrl_wr;
  logic [7:0]        devadr;

  cf_window_dec #(.ADDR_W(ADDR_W)) u_win (
    .mode_i (mode_i),
    .addr_i (addr_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  cf_byte_pair #(.DATA_W(DATA_W)) u_pair (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_step_i (wr_step),
    .wr_odd_i  (wr_odd),
    .rd_step_i (rd_step),
    .wbyte_i   (wdata_i[BYTE_W-1:0]),
    .fetch_i   (tf_rdata_i),
    .cycle_o   (cycle),
    .latch_o   (latch)
  );

  cf_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctrl_wr),
    .wdata_i (wdata_i[7:0]),
    .ctrl_o  (ctrl_o),
    .srst_o  (soft_rst_o),
    .eval_o  (irq_eval_o)
  );

  assign devadr = DEVADR_BASE | {2'b00, ~sel_nib_i, 2'b00};

  always_comb begin
    tf_req_o   = 1'b0;
    tf_we_o    = 1'b0;
    tf_idx_o   = idx;
    tf_wdata_o = wdata_i;
    rdata_o    = '1;
    wake_o     = 1'b0;
    ctrl_wr    = 1'b0;
    wr_step    = 1'b0;
    wr_odd     = 1'b0;
    rd_step    = 1'b0;
    if (req_i && hit) begin
      rdata_o = '0;
      case (idx)
        IDX_DATA: begin
          tf_req_o = 1'b1;
          tf_we_o  = we_i;
          rdata_o  = tf_rdata_i;
        end
        IDX_BYTE: begin
          tf_idx_o = IDX_DATA;
          if (we_i) begin
            wr_step = 1'b1;
            if (cycle) begin
              tf_req_o   = 1'b1;
              tf_we_o    = 1'b1;
              tf_wdata_o = {wdata_i[BYTE_W-1:0], latch[BYTE_W-1:0]};
            end
          end else begin
            rd_step = 1'b1;
            if (cycle) begin
              rdata_o = {ZB, latch[DATA_W-1:BYTE_W]};
            end else begin
              tf_req_o = 1'b1;
              rdata_o  = {ZB, tf_rdata_i[BYTE_W-1:0]};
            end
          end
        end
        IDX_ODD: begin
          if (we_i) wr_odd = 1'b1;
          else      rdata_o = {ZB, latch[DATA_W-1:BYTE_W]};
        end
        IDX_ERRFEAT: begin
          tf_req_o = 1'b1;
          tf_we_o  = we_i;
          tf_idx_o = IDX_TF_ERR;
          rdata_o  = tf_rdata_i;
        end
        IDX_ALTCTL: begin
          if (we_i) ctrl_wr = 1'b1;
          else      rdata_o = DATA_W'(alt_stat_i);
        end
        IDX_DEVADR: begin
          if (we_i) begin
            tf_req_o = 1'b1;
            tf_we_o  = 1'b1;
            wake_o   = pwrdn_i;
          end else begin
            rdata_o = DATA_W'(devadr);
          end
        end
        default: begin
          tf_req_o = 1'b1;
          tf_we_o  = we_i;
          rdata_o  = tf_rdata_i;
          wake_o   = we_i & pwrdn_i;
        end
      endcase
    end
  end

  // R5: a miss is silent
  a_r5_miss_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !hit) |-> (!tf_req_o && !wake_o && !irq_eval_o && rdata_o == '1));
  // R9: second half of a byte read never refetches
  a_r9_no_refetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && hit && !we_i && idx == IDX_BYTE && cycle) |-> !tf_req_o);
  // R13: wake only on a forwarded write while powered down
  a_r13_wake_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (pwrdn_i && tf_req_o && tf_we_o));
  // R6 / R7: task-file traffic only inside an access
  a_r6_tf_in_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf_req_o |-> (req_i && hit));
endmodule

// File: tb/tb_cf_common_decoder.sv
module tb_cf_common_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        req = 1'b0, we = 1'b0;
  logic [10:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        tf_req, tf_we;
  logic [3:0]  tf_idx;
  logic [15:0] tf_wdata, tf_rdata;
  logic [7:0]  alt_stat = 8'h50;
  logic [3:0]  sel_nib = 4'h0;
  logic        pwrdn = 1'b0, wake, soft_rst, irq_eval;
  logic [7:0]  ctrl;
  logic [15:0] data_word = 16'hBEEF;

  int checks = 0, fails = 0;
  bit done = 0;

  // sampled outputs
  logic [15:0] s_rd, s_twd;
  logic        s_treq, s_twe, s_wake, s_srst, s_eval;
  logic [3:0]  s_tidx;

  always #5 clk = ~clk;

  function automatic logic [15:0] stub(input logic [3:0] i);
    return (i == 4'h0) ? data_word : {8'h5A, 4'h0, i};
  endfunction
  assign tf_rdata = stub(tf_idx);

  cf_common_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .tf_req_o(tf_req), .tf_we_o(tf_we), .tf_idx_o(tf_idx),
    .tf_wdata_o(tf_wdata), .tf_rdata_i(tf_rdata),
    .alt_stat_i(alt_stat), .sel_nib_i(sel_nib), .pwrdn_i(pwrdn),
    .wake_o(wake), .ctrl_o(ctrl), .soft_rst_o(soft_rst), .irq_eval_o(irq_eval)
  );

  task automatic chk(input bit ok, input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] m, input logic w, input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    mode = m; req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    s_rd = rdata; s_treq = tf_req; s_twe = tf_we; s_tidx = tf_idx; s_twd = tf_wdata;
    s_wake = wake; s_srst = soft_rst; s_eval = irq_eval;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  // {mode, addr, hit, idx}
  localparam logic [17:0] VEC [14] = '{
    {2'd0, 11'h401, 1'b1, 4'h1},
    {2'd0, 11'h40B, 1'b1, 4'hB},
    {2'd0, 11'h5F3, 1'b1, 4'h3},
    {2'd0, 11'h001, 1'b0, 4'h0},
    {2'd0, 11'h203, 1'b0, 4'h0},
    {2'd1, 11'h123, 1'b1, 4'h3},
    {2'd1, 11'h00A, 1'b1, 4'hA},
    {2'd2, 11'h1F2, 1'b1, 4'h2},
    {2'd2, 11'h3F3, 1'b1, 4'hB},
    {2'd2, 11'h172, 1'b0, 4'h0},
    {2'd3, 11'h175, 1'b1, 4'h5},
    {2'd3, 11'h373, 1'b1, 4'hB},
    {2'd3, 11'h1F2, 1'b0, 4'h0},
    {2'd3, 11'h3F3, 1'b0, 4'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R14 reset state
    chk(ctrl == 8'h00, "R14 ctrl", {8'h0, ctrl}, 16'h0);
    acc(2'd1, 1'b0, 11'h009, 16'h0);
    chk(s_rd == 16'h0000 && !s_treq, "R14 latch clear", s_rd, 16'h0);
    data_word = 16'hBEEF;
    acc(2'd1, 1'b0, 11'h008, 16'h0);
    chk(s_treq && s_rd == 16'h00EF, "R14 toggle clear", s_rd, 16'h00EF);
    acc(2'd1, 1'b0, 11'h008, 16'h0);

    // R1-R4 window table
    for (int i = 0; i < 14; i++) begin
      logic [15:0] e;
      acc(VEC[i][17:16], 1'b0, VEC[i][15:5], 16'h0);
      e = VEC[i][4] ? {8'h5A, 4'h0, VEC[i][3:0]} : 16'hFFFF;
      chk(s_rd == e && s_treq == VEC[i][4] && (!VEC[i][4] || s_tidx == VEC[i][3:0]),
          "R1_R2_R3_R4 window", s_rd, e);
    end

    // R3 / R4 upper-window local registers
    acc(2'd2, 1'b0, 11'h3F6, 16'h0);
    chk(s_rd == 16'h0050 && !s_treq, "R3 alt status", s_rd, 16'h0050);
    sel_nib = 4'h5;
    acc(2'd2, 1'b0, 11'h3F7, 16'h0);
    chk(s_rd == 16'h00EA, "R3 devaddr", s_rd, 16'h00EA);
    acc(2'd3, 1'b0, 11'h376, 16'h0);
    chk(s_rd == 16'h0050 && !s_treq, "R4 alt status", s_rd, 16'h0050);

    // R12 device address
    sel_nib = 4'h0;
    acc(2'd1, 1'b0, 11'h00F, 16'h0);
    chk(s_rd == 16'h00FE, "R12 sel0", s_rd, 16'h00FE);
    sel_nib = 4'hF;
    acc(2'd1, 1'b0, 11'h00F, 16'h0);
    chk(s_rd == 16'h00C2, "R12 selF", s_rd, 16'h00C2);

    // R6 16-bit data port
    acc(2'd1, 1'b1, 11'h000, 16'h1234);
    chk(s_treq && s_twe && s_tidx == 4'h0 && s_twd == 16'h1234, "R6 write", s_twd, 16'h1234);
    data_word = 16'hBEEF;
    acc(2'd1, 1'b0, 11'h000, 16'h0);
    chk(s_rd == 16'hBEEF && s_tidx == 4'h0, "R6 read", s_rd, 16'hBEEF);

    // R7 even/even pairing
    acc(2'd1, 1'b1, 11'h008, 16'hAA11);
    chk(!s_treq, "R7 first byte held", {15'h0, s_treq}, 16'h0);
    acc(2'd1, 1'b1, 11'h008, 16'hBB22);
    chk(s_treq && s_twe && s_tidx == 4'h0 && s_twd == 16'h2211, "R7 pair", s_twd, 16'h2211);

    // R8 odd then even
    acc(2'd1, 1'b1, 11'h009, 16'h0033);
    chk(!s_treq, "R8 odd latched", {15'h0, s_treq}, 16'h0);
    acc(2'd1, 1'b1, 11'h008, 16'h0044);
    chk(s_treq && s_twe && s_twd == 16'h4433, "R8 pair", s_twd, 16'h4433);

    // R9 byte reads
    data_word = 16'hCAFE;
    acc(2'd0, 1'b0, 11'h408, 16'h0);
    chk(s_treq && s_tidx == 4'h0 && s_rd == 16'h00FE, "R9 low byte", s_rd, 16'h00FE);
    data_word = 16'h0000;
    acc(2'd0, 1'b0, 11'h408, 16'h0);
    chk(!s_treq && s_rd == 16'h00CA, "R9 high byte", s_rd, 16'h00CA);
    acc(2'd0, 1'b0, 11'h409, 16'h0);
    chk(s_rd == 16'h00CA && !s_treq, "R9 odd read", s_rd, 16'h00CA);

    // R10 error/features
    acc(2'd2, 1'b1, 11'h1FD, 16'h0077);
    chk(s_treq && s_twe && s_tidx == 4'h1 && s_twd == 16'h0077, "R10 features", s_twd, 16'h0077);
    acc(2'd2, 1'b0, 11'h1FD, 16'h0);
    chk(s_rd == 16'h5A01, "R10 error", s_rd, 16'h5A01);

    // R11 device control
    acc(2'd2, 1'b1, 11'h3F6, 16'h0002);
    chk(s_eval && !s_srst && !s_treq, "R11 eval", {14'h0, s_eval, s_srst}, 16'h2);
    chk(ctrl == 8'h02, "R11 ctrl load", {8'h0, ctrl}, 16'h0002);
    acc(2'd2, 1'b1, 11'h3F6, 16'h0006);
    chk(s_eval && s_srst, "R11 srst", {14'h0, s_eval, s_srst}, 16'h3);

    // R13 wake on forwarded write
    pwrdn = 1'b1;
    acc(2'd1, 1'b1, 11'h003, 16'h0055);
    chk(s_wake && s_treq && s_twe && s_tidx == 4'h3, "R13 wake", {15'h0, s_wake}, 16'h1);
    acc(2'd1, 1'b1, 11'h00E, 16'h0006);
    chk(!s_wake, "R13 no wake on ctrl", {15'h0, s_wake}, 16'h0);
    pwrdn = 1'b0;
    acc(2'd1, 1'b1, 11'h003, 16'h0055);
    chk(!s_wake && s_treq, "R13 awake", {15'h0, s_wake}, 16'h0);

    // R5 missed writes change nothing
    acc(2'd2, 1'b1, 11'h17E, 16'h00FF);
    chk(!s_treq && !s_eval, "R5 miss write", {15'h0, s_treq}, 16'h0);
    chk(ctrl == 8'h06, "R5 ctrl kept", {8'h0, ctrl}, 16'h0006);
    acc(2'd2, 1'b1, 11'h178, 16'h0099);
    acc(2'd2, 1'b1, 11'h1F8, 16'h0011);
    chk(!s_treq, "R5 toggle kept", {15'h0, s_treq}, 16'h0);
    acc(2'd2, 1'b1, 11'h1F8, 16'h0022);
    chk(s_treq && s_twd == 16'h2211, "R5 pair after miss", s_twd, 16'h2211);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule